// File: doc/BRIEF.md
# Flash Identification Read Mode

This block sits behind the command decoder of a flash memory interface and owns the identification mode. A single-cycle command pulse either enters ID mode or returns to normal read mode. While ID mode is active, a read no longer returns array data. The low part of the read address selects what comes back instead: the manufacturer code, the device code, or the write-protect bit of the sector that the upper address bits name.

After reset the block is in normal read mode and passes array data straight through. It stays in whichever mode it is in until a command that changes the mode arrives. Read data is registered and is updated only on a read strobe. The command unlock sequence is decoded upstream, and the block sees only the decoded result.

Top module: `flash_id_read`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `id_mode` is 0 and `rd_data` is 0. Once reset is released, the block is in normal read mode.
- R2: In normal mode, a cycle with `rd_en` high loads `array_data` into `rd_data`, visible after that clock edge.
- R3: A command pulse with `cmd_code` = 2'b01 (ID) sets `id_mode` to 1 at the next edge. ID mode then persists through any number of reads and cycles that carry no command.
- R4: In ID mode, a read whose in-sector offset `rd_addr[11:0]` equals 000h returns the manufacturer code parameter.
- R5: In ID mode, a read at offset 001h returns the device code parameter.
- R6: In ID mode, a read at offset 002h returns the protect bit of sector `rd_addr[16:12]`, taken from `sect_prot[sector]`, on bit 0. All other data bits read 0.
- R7: In ID mode, a read at any other offset, including offsets whose bits 11:8 are non-zero, returns 00h.
- R8: A command pulse with `cmd_code` = 2'b10 (read/reset) clears `id_mode` at the next edge. Later reads return array data.
- R9: While `rd_en` is low, `rd_data` holds its value, whatever the address, array data or mode does.
- R10: Command pulses with code 2'b00 or 2'b11 have no effect on the mode.
- R11: A read in the same cycle as a mode-changing command is served in the mode that was in force before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle decoded command pulse |
| cmd_code | input | 2 | 01 = ID read, 10 = read/reset, others reserved |
| rd_addr | input | 17 | Read address; [16:12] sector, [11:0] offset |
| sect_prot | input | 32 | Write-protect bit per sector |
| array_data | input | 8 | Data from the memory array |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| id_mode | output | 1 | 1 while ID mode is active |

## Verification
The assertions assume that `cmd_valid` is a clean synchronous pulse and that its code is sampled only when the pulse is high. They also assume that `array_data` and `sect_prot` are stable for the cycle in which a read is strobed. The stimulus drives every input on the falling edge, one full half period before the sampling edge. It asserts reset asynchronously in mid-run and releases it on a falling edge, so the internal synchronizer always sees clean levels. Commands and reads are deliberately overlapped to exercise the old-mode rule.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_ID   = 2'b01,
    CMD_RST  = 2'b10,
    CMD_RSVD = 2'b11
  } fid_cmd_e;
endpackage

// File: rtl/fid_rst_sync.sv
module fid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign chain_nxt[s] = 1'b1;
      end else begin : g_rest
        assign chain_nxt[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fid_mode_ctrl.sv
module fid_mode_ctrl
  import flash_id_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  output logic       id_mode
);
  fid_cmd_e cmd;
  logic     mode_q;
  logic     mode_nxt;

  assign cmd = fid_cmd_e'(cmd_code);

  always_comb begin
    mode_nxt = mode_q;
    if (cmd_valid) begin
      case (cmd)
        CMD_ID:  mode_nxt = 1'b1;
        CMD_RST: mode_nxt = 1'b0;
        default: mode_nxt = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_nxt;
  end

  assign id_mode = mode_q;

  p_id_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 2'b01) |=> id_mode);
  p_persist_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(id_mode));
  p_reset_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 2'b10) |=> !id_mode);
  p_rsvd_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == 2'b00 || cmd_code == 2'b11)) |=> $stable(id_mode));
endmodule

// File: rtl/fid_id_sel.sv
module fid_id_sel #(
  parameter int          ADDR_W   = 17,
  parameter int          SECT_LSB = 12,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  MFR_CODE = 8'h3C,
  parameter logic [7:0]  DEV_CODE = 8'h5B,
  localparam int         SECT_W   = ADDR_W - SECT_LSB,
  localparam int         NUM_SECT = 1 << SECT_W
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_SECT-1:0] sect_prot,
  output logic [DATA_W-1:0]   id_word
);
  localparam logic [SECT_LSB-1:0] OFS_MFR  = SECT_LSB'(0);
  localparam logic [SECT_LSB-1:0] OFS_DEV  = SECT_LSB'(1);
  localparam logic [SECT_LSB-1:0] OFS_PROT = SECT_LSB'(2);

  logic [SECT_LSB-1:0] offset;
  logic [SECT_W-1:0]   sector;

  assign offset = addr[SECT_LSB-1:0];
  assign sector = addr[ADDR_W-1:SECT_LSB];

  always_comb begin
    id_word = '0;
    case (offset)
      OFS_MFR:  id_word = DATA_W'(MFR_CODE);
      OFS_DEV:  id_word = DATA_W'(DEV_CODE);
      OFS_PROT: id_word[0] = sect_prot[sector];
      default:  id_word = '0;
    endcase
  end
endmodule

// File: rtl/flash_id_read.sv
module flash_id_read #(
  parameter int         ADDR_W      = 17,
  parameter int         SECT_LSB    = 12,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MFR_CODE    = 8'h3C,
  parameter logic [7:0] DEV_CODE    = 8'h5B,
  localparam int        NUM_SECT    = 1 << (ADDR_W - SECT_LSB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_code,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_SECT-1:0] sect_prot,
  input  logic [DATA_W-1:0]   array_data,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  output logic                id_mode
);
  logic              rst_int_n;
  logic [DATA_W-1:0] id_word;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_nxt;

  fid_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  fid_mode_ctrl i_mode_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .id_mode   (id_mode)
  );

  fid_id_sel #(
    .ADDR_W   (ADDR_W),
    .SECT_LSB (SECT_LSB),
    .DATA_W   (DATA_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) i_id_sel (
    .addr      (rd_addr),
    .sect_prot (sect_prot),
    .id_word   (id_word)
  );

  always_comb begin
    data_nxt = data_q;
    if (rd_en) data_nxt = id_mode ? id_word : array_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) data_q <= '0;
    else            data_q <= data_nxt;
  end

  assign rd_data = data_q;

  p_array_pass_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && !id_mode) |=> rd_data == $past(array_data));
  p_prot_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && id_mode && rd_addr[SECT_LSB-1:0] == SECT_LSB'(2))
      |=> rd_data[DATA_W-1:1] == '0);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_en |=> $stable(rd_data));
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (rd_data == '0 && !id_mode));
endmodule

// File: tb/test_flash_id_read.sv
module test_flash_id_read;
  localparam logic [7:0] MFR = 8'h3C;
  localparam logic [7:0] DEV = 8'h5B;
  localparam logic [31:0] PROT = 32'h8000_0005;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic [16:0] rd_addr;
  logic [31:0] sect_prot;
  logic [7:0]  array_data;
  logic        rd_en;
  logic [7:0]  rd_data;
  logic        id_mode;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #2.5 clk = ~clk;

  flash_id_read #(.MFR_CODE(MFR), .DEV_CODE(DEV)) i_flash_id_read (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rd_addr(rd_addr), .sect_prot(sect_prot), .array_data(array_data),
    .rd_en(rd_en), .rd_data(rd_data), .id_mode(id_mode)
  );

  typedef struct packed {
    logic        cv;
    logic [1:0]  cmd;
    logic [16:0] addr;
    logic [31:0] prot;
    logic [7:0]  arr;
    logic        rd;
    logic        exp_mode;
    logic [7:0]  exp_data;
  } vec_t;

  // cmd: 01 ID, 10 read/reset, 00/11 ignored; offset addr[11:0], sector addr[16:12]
  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b00, 17'h00000, PROT,  8'h11, 1'b1, 1'b0, 8'h11}, // R2
    '{1'b0, 2'b00, 17'h00001, PROT,  8'h22, 1'b1, 1'b0, 8'h22}, // R2
    '{1'b1, 2'b01, 17'h00000, PROT,  8'h33, 1'b0, 1'b1, 8'h22}, // R3 R9
    '{1'b0, 2'b00, 17'h00000, PROT,  8'h44, 1'b1, 1'b1, MFR},   // R4
    '{1'b0, 2'b00, 17'h00001, PROT,  8'h44, 1'b1, 1'b1, DEV},   // R5
    '{1'b0, 2'b00, 17'h00002, PROT,  8'h44, 1'b1, 1'b1, 8'h01}, // R6 s0
    '{1'b0, 2'b00, 17'h01002, PROT,  8'h44, 1'b1, 1'b1, 8'h00}, // R6 s1
    '{1'b0, 2'b00, 17'h02002, PROT,  8'hFF, 1'b1, 1'b1, 8'h01}, // R6 s2
    '{1'b0, 2'b00, 17'h1F002, PROT,  8'hFF, 1'b1, 1'b1, 8'h01}, // R6 s31
    '{1'b0, 2'b00, 17'h00003, PROT,  8'hFF, 1'b1, 1'b1, 8'h00}, // R7
    '{1'b0, 2'b00, 17'h000FF, PROT,  8'hFF, 1'b1, 1'b1, 8'h00}, // R7
    '{1'b0, 2'b00, 17'h00F00, PROT,  8'hFF, 1'b1, 1'b1, 8'h00}, // R7
    '{1'b1, 2'b00, 17'h00001, PROT,  8'hFF, 1'b1, 1'b1, DEV},   // R10
    '{1'b1, 2'b11, 17'h00000, PROT,  8'hFF, 1'b0, 1'b1, DEV},   // R10
    '{1'b1, 2'b10, 17'h00000, PROT,  8'h77, 1'b1, 1'b0, MFR},   // R11
    '{1'b0, 2'b00, 17'h00000, PROT,  8'h77, 1'b1, 1'b0, 8'h77}, // R8
    '{1'b1, 2'b01, 17'h00002, PROT,  8'h99, 1'b1, 1'b1, 8'h99}, // R11
    '{1'b0, 2'b00, 17'h00002, 32'h0, 8'h99, 1'b1, 1'b1, 8'h00}  // R6
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cmd_valid = 1'b0; cmd_code = 2'b00; rd_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rd_addr = '0; sect_prot = PROT; array_data = 8'h00;
    rst_n = 1'b0;
    #1;
    check("R1 reset mode", {7'd0, id_mode}, 8'h00);
    check("R1 reset data", rd_data, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 mode after release", {7'd0, id_mode}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cmd_valid  = VEC[i].cv;
      cmd_code   = VEC[i].cmd;
      rd_addr    = VEC[i].addr;
      sect_prot  = VEC[i].prot;
      array_data = VEC[i].arr;
      rd_en      = VEC[i].rd;
      @(posedge clk);
      #1;
      check($sformatf("vec %0d mode (R3 R8 R10)", i), {7'd0, id_mode}, {7'd0, VEC[i].exp_mode});
      check($sformatf("vec %0d data (R2 R4-R7 R11)", i), rd_data, VEC[i].exp_data);
    end

    // R9: strobe low in normal mode, array data and address move
    @(negedge clk);
    idle();
    cmd_valid = 1'b1; cmd_code = 2'b10;
    @(negedge clk);
    idle();
    rd_en = 1'b1; array_data = 8'hA1;
    @(negedge clk);
    idle();
    array_data = 8'hB2; rd_addr = 17'h00001;
    repeat (3) @(negedge clk);
    check("R9 hold with strobe low", rd_data, 8'hA1);

    // R1: reset in the middle of ID mode
    cmd_valid = 1'b1; cmd_code = 2'b01;
    @(negedge clk);
    idle();
    rd_en = 1'b1; rd_addr = 17'h00000;
    @(negedge clk);
    idle();
    check("R4 before reset", rd_data, MFR);
    rst_n = 1'b0;
    #1;
    check("R1 async data clear", rd_data, 8'h00);
    check("R1 async mode clear", {7'd0, id_mode}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_en = 1'b1; array_data = 8'h44; rd_addr = 17'h00000;
    @(negedge clk);
    idle();
    check("R1 normal read after reset", rd_data, 8'h44);
    check("R1 mode after reset", {7'd0, id_mode}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule